// File: doc/BRIEF.md
# Television Sync Timing Generator with Separate or Composite Modes

This block derives television line and field timing from a dot clock. It produces a horizontal sync pulse, a vertical sync pulse and an active-low vertical blanking window. It can run on its own dot and line counters. It can also follow active-low sync pulses that arrive from an external video source. When it follows an external source, it passes those pulses through a synchronizer and restarts its counters on their falling edges.

Two independent control inputs choose separate or composite operation. On the output side, composite mode puts the XNOR of the active-low horizontal and vertical sync onto the horizontal pin. The horizontal pulses therefore appear inverted during the vertical sync lines, and the vertical pin is held high. On the input side, composite mode ignores the external vertical input. It detects field start from a low period on the horizontal input that lasts half a line. Line length, sync widths, lines per field and blanking lines are all parameters. The defaults are NTSC-like: 858 dots, 525 lines and 9 blanking lines.

Top module: `sync_gen_top`

## Requirements
- R1: When `ext_lock` is 0, the dot counter runs 0 to LINE_DOTS-1 and wraps. The internal horizontal sync is active on dots 0 to HSYNC_W-1 of every line. With `out_comp` 0, `hsync_n` is low exactly then.
- R2: When `ext_lock` is 0, the line counter advances when the dot counter wraps and runs 0 to FIELD_LINES-1. The internal vertical sync is active on lines 0 to VSYNC_LINES-1. With `out_comp` 0, `vsync_n` is low exactly then.
- R3: In every mode, `vblank_n` is low on lines 0 to VBLANK_LINES-1 and high otherwise.
- R4: With `out_comp` 1, `hsync_n` equals NOT(hs_active XOR vs_active). Here hs_active and vs_active are the internal sync conditions of R1 and R2.
- R5: With `out_comp` 1, `vsync_n` is held at 1.
- R6: With `ext_lock` 1, a falling edge on `ext_hs_n` passes through a two-flop synchronizer. The line it starts has dot 0 in the clock cycle that follows the third rising edge, counting the edge that first samples the low level. The same event advances the line counter, which wraps at FIELD_LINES. Without such an edge, the dot counter still wraps, but the line counter holds.
- R7: With `ext_lock` 1 and `in_comp` 0, a synchronized falling edge on `ext_vs_n` sets the line counter to 0 with the same latency as R6. This has priority over a line advance in the same cycle.
- R8: With `ext_lock` 1 and `in_comp` 1, `ext_vs_n` has no effect. When the synchronized `ext_hs_n` stays low for LINE_DOTS/2 consecutive samples, the line counter is set to 0 on the next edge. This happens once per low period.
- R9: After reset, both counters are 0. With `out_comp` 0 this gives `hsync_n`=0, `vsync_n`=0 and `vblank_n`=0. With `out_comp` 1 it gives `hsync_n`=1, `vsync_n`=1 and `vblank_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lock | input | 1 | 1: follow external sync, 0: free-run |
| in_comp | input | 1 | 1: treat ext_hs_n as composite sync |
| out_comp | input | 1 | 1: composite sync on hsync_n, vsync_n held high |
| ext_hs_n | input | 1 | External horizontal or composite sync, active low |
| ext_vs_n | input | 1 | External vertical sync, active low |
| hsync_n | output | 1 | Horizontal or composite sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| vblank_n | output | 1 | Vertical blanking window, active low |

## Verification
The assertions assume that the three mode inputs are static between resets and that VSYNC_LINES does not exceed VBLANK_LINES. The stimulus meets this in two ways. It changes modes only while reset is held, and its small configuration uses 2 sync lines inside a 4-line blanking window. External pulses are driven on the falling clock edge and are held low for at least two clocks. This lets every edge pass through the synchronizer. Composite-input stimulus includes a low period just short of half a line, and a period long enough to start a field.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    // Mode controls gathered in one place
    typedef struct packed {
        logic lock;      // follow external sync
        logic in_comp;   // external horizontal input carries composite sync
        logic out_comp;  // horizontal output carries composite sync
    } sync_mode_t;

    // Events produced by the input stage for the timing core
    typedef struct packed {
        logic line_start;   // synchronized falling edge on horizontal input
        logic field_start;  // vertical start, separate or recovered
    } sync_evt_t;

endpackage

// File: rtl/sync_in_stage.sv
module sync_in_stage
    import sync_gen_pkg::*;
#(
    parameter int LINE_DOTS   = 858,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_comp,
    input  logic      ext_hs_n,
    input  logic      ext_vs_n,
    output sync_evt_t evt
);
    localparam int HALF = LINE_DOTS / 2;
    localparam int LW   = $clog2(HALF + 1);
    localparam int SW   = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] hs_sh;
        logic [SW-1:0] vs_sh;
        logic [LW-1:0] lo_cnt;
    } in_state_t;

    in_state_t st_d, st_q;
    logic      h_fall, v_fall, v_det, hs_now;

    always_comb begin
        st_d       = st_q;
        st_d.hs_sh = {st_q.hs_sh[SW-2:0], ext_hs_n};
        st_d.vs_sh = {st_q.vs_sh[SW-2:0], ext_vs_n};

        hs_now = st_q.hs_sh[SW-2];
        h_fall = st_q.hs_sh[SW-1] & ~hs_now;
        v_fall = st_q.vs_sh[SW-1] & ~st_q.vs_sh[SW-2];

        // low-duration counter saturates at HALF so detection fires once
        if (hs_now) begin
            st_d.lo_cnt = '0;
        end else if (st_q.lo_cnt != LW'(HALF)) begin
            st_d.lo_cnt = st_q.lo_cnt + 1'b1;
        end
        v_det = ~hs_now && (st_q.lo_cnt == LW'(HALF - 1));

        evt.line_start  = h_fall;
        evt.field_start = in_comp ? v_det : v_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hs_sh  <= '1;
            st_q.vs_sh  <= '1;
            st_q.lo_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sync_timing_core.sv
module sync_timing_core
    import sync_gen_pkg::*;
#(
    parameter int LINE_DOTS   = 858,
    parameter int FIELD_LINES = 525,
    localparam int HW = $clog2(LINE_DOTS),
    localparam int VW = $clog2(FIELD_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  sync_evt_t     evt,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt
);
    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       h_last;
    logic [VW-1:0] v_inc;

    always_comb begin
        st_d   = st_q;
        h_last = (st_q.h == HW'(LINE_DOTS - 1));
        v_inc  = (st_q.v == VW'(FIELD_LINES - 1)) ? '0 : st_q.v + 1'b1;

        if (lock && evt.line_start) begin
            st_d.h = '0;
        end else begin
            st_d.h = h_last ? '0 : st_q.h + 1'b1;
        end

        if (!lock) begin
            if (h_last) begin
                st_d.v = v_inc;
            end
        end else if (evt.field_start) begin
            st_d.v = '0;
        end else if (evt.line_start) begin
            st_d.v = v_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_cnt = st_q.h;
    assign v_cnt = st_q.v;

endmodule

// File: rtl/sync_out_mux.sv
module sync_out_mux #(
    parameter int HSYNC_W      = 64,
    parameter int VSYNC_LINES  = 3,
    parameter int VBLANK_LINES = 9,
    parameter int HW           = 10,
    parameter int VW           = 10
) (
    input  logic [HW-1:0] h_cnt,
    input  logic [VW-1:0] v_cnt,
    input  logic          out_comp,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          vblank_n
);
    logic hs_n, vs_n;

    always_comb begin
        hs_n     = !(h_cnt < HW'(HSYNC_W));
        vs_n     = !(v_cnt < VW'(VSYNC_LINES));
        vblank_n = !(v_cnt < VW'(VBLANK_LINES));
        if (out_comp) begin
            hsync_n = ~(hs_n ^ vs_n);
            vsync_n = 1'b1;
        end else begin
            hsync_n = hs_n;
            vsync_n = vs_n;
        end
    end

endmodule

// File: rtl/sync_gen_top.sv
module sync_gen_top
    import sync_gen_pkg::*;
#(
    parameter int LINE_DOTS    = 858,
    parameter int HSYNC_W      = 64,
    parameter int FIELD_LINES  = 525,
    parameter int VSYNC_LINES  = 3,
    parameter int VBLANK_LINES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_lock,
    input  logic in_comp,
    input  logic out_comp,
    input  logic ext_hs_n,
    input  logic ext_vs_n,
    output logic hsync_n,
    output logic vsync_n,
    output logic vblank_n
);
    localparam int HW = $clog2(LINE_DOTS);
    localparam int VW = $clog2(FIELD_LINES);

    sync_mode_t    mode;
    sync_evt_t     evt;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          line_start;

    assign mode       = '{lock: ext_lock, in_comp: in_comp, out_comp: out_comp};
    assign line_start = evt.line_start;

    sync_in_stage #(
        .LINE_DOTS  (LINE_DOTS),
        .SYNC_STAGES(2)
    ) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_comp (mode.in_comp),
        .ext_hs_n(ext_hs_n),
        .ext_vs_n(ext_vs_n),
        .evt     (evt)
    );

    sync_timing_core #(
        .LINE_DOTS  (LINE_DOTS),
        .FIELD_LINES(FIELD_LINES)
    ) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .lock (mode.lock),
        .evt  (evt),
        .h_cnt(h_cnt),
        .v_cnt(v_cnt)
    );

    sync_out_mux #(
        .HSYNC_W     (HSYNC_W),
        .VSYNC_LINES (VSYNC_LINES),
        .VBLANK_LINES(VBLANK_LINES),
        .HW          (HW),
        .VW          (VW)
    ) u_out (
        .h_cnt   (h_cnt),
        .v_cnt   (v_cnt),
        .out_comp(mode.out_comp),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .vblank_n(vblank_n)
    );

endmodule

// File: rtl/sync_gen_chk.sv
module sync_gen_chk #(
    parameter int LINE_DOTS   = 858,
    parameter int FIELD_LINES = 525,
    parameter int HW          = 10,
    parameter int VW          = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_lock,
    input logic          out_comp,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic          line_start,
    input logic          vsync_n,
    input logic          vblank_n
);
    a_r5_vsync_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        out_comp |-> vsync_n);

    a_r3_vsync_inside_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_comp && !vsync_n) |-> !vblank_n);

    a_r1_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_lock && h_cnt == HW'(LINE_DOTS - 1)) |=> (h_cnt == '0));

    a_r6_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_lock && line_start) |=> (h_cnt == '0));

    a_r2_count_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt < HW'(LINE_DOTS)) && (v_cnt < VW'(FIELD_LINES)));

endmodule

bind sync_gen_top sync_gen_chk #(
    .LINE_DOTS  (LINE_DOTS),
    .FIELD_LINES(FIELD_LINES),
    .HW         (HW),
    .VW         (VW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_lock  (ext_lock),
    .out_comp  (out_comp),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .line_start(line_start),
    .vsync_n   (vsync_n),
    .vblank_n  (vblank_n)
);

// File: tb/sync_gen_top_tb.sv
module sync_gen_top_tb;
    localparam int LD = 20;
    localparam int HS = 3;
    localparam int FL = 12;
    localparam int VS = 2;
    localparam int VB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_lock = 1'b0, in_comp = 1'b0, out_comp = 1'b0;
    logic ext_hs_n = 1'b1, ext_vs_n = 1'b1;
    logic hsync_n, vsync_n, vblank_n;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state, derived from the requirements
    int       mh, mv, mlo;
    logic [2:0] msh, msv;

    always #5 clk = ~clk;

    sync_gen_top #(
        .LINE_DOTS(LD), .HSYNC_W(HS), .FIELD_LINES(FL),
        .VSYNC_LINES(VS), .VBLANK_LINES(VB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_lock(ext_lock), .in_comp(in_comp),
        .out_comp(out_comp), .ext_hs_n(ext_hs_n), .ext_vs_n(ext_vs_n),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .vblank_n(vblank_n)
    );

    task automatic check(input string tag);
        logic hs_a, vs_a, eh, ev, eb;
        hs_a = (mh < HS);
        vs_a = (mv < VS);
        eh   = out_comp ? ~(hs_a ^ vs_a) : ~hs_a;
        ev   = out_comp ? 1'b1 : ~vs_a;
        eb   = ~(mv < VB);
        n_chk++;
        if ({hsync_n, vsync_n, vblank_n} !== {eh, ev, eb}) begin
            n_bad++;
            $display("FAIL %s: hsync/vsync/vblank = %b%b%b expected %b%b%b (dot %0d line %0d)",
                     tag, hsync_n, vsync_n, vblank_n, eh, ev, eb, mh, mv);
        end
    endtask

    // advance the model across one rising edge with the inputs now applied
    task automatic model_edge();
        logic fh, fv, vd;
        int   nh, nv, nlo;
        fh  = msh[2] & ~msh[1];
        fv  = msv[2] & ~msv[1];
        vd  = in_comp && !msh[1] && (mlo == LD/2 - 1);
        nlo = msh[1] ? 0 : ((mlo == LD/2) ? mlo : mlo + 1);
        nh  = (ext_lock && fh) ? 0 : ((mh == LD-1) ? 0 : mh + 1);
        if (!ext_lock) nv = (mh == LD-1) ? (mv + 1) % FL : mv;
        else if (in_comp ? vd : fv) nv = 0;
        else if (fh) nv = (mv + 1) % FL;
        else nv = mv;
        mh = nh; mv = nv; mlo = nlo;
        msh = {msh[1:0], ext_hs_n};
        msv = {msv[1:0], ext_vs_n};
    endtask

    task automatic tick(input string tag);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset(input logic lk, input logic ic, input logic oc);
        @(negedge clk);
        rst_n = 1'b0;
        ext_hs_n = 1'b1; ext_vs_n = 1'b1;
        ext_lock = lk; in_comp = ic; out_comp = oc;
        mh = 0; mv = 0; mlo = 0; msh = '1; msv = '1;
        @(negedge clk);
        check("R9 reset state");
        rst_n = 1'b1;
    endtask

    // one externally timed line: horizontal low for 'w' dots of 'len'
    task automatic ext_line(input int len, input int w, input bit vlow,
                            input bit vnoise, input string tag);
        for (int i = 0; i < len; i++) begin
            ext_hs_n = (i >= w);
            if (vnoise)    ext_vs_n = ((i % 7) >= 3);
            else if (vlow) ext_vs_n = (i >= w);
            else           ext_vs_n = 1'b1;
            tick(tag);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // free run, separate outputs: two full fields (R1 R2 R3)
        do_reset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 2*LD*FL; i++) tick("R1 R2 R3 free run");

        // free run, composite output (R4 R5)
        do_reset(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < LD*FL + 7; i++) tick("R4 R5 composite out");

        // locked, separate input (R6 R7)
        do_reset(1'b1, 1'b0, 1'b0);
        ext_line(10, 2, 1'b1, 1'b0, "R7 field start with line");
        for (int l = 0; l < 14; l++) ext_line(10, 2, 1'b0, 1'b0, "R6 line follow");
        ext_line(33, 2, 1'b0, 1'b0, "R6 long line dot wrap, line holds");
        ext_line(7, 3, 1'b0, 1'b0, "R6 short line");
        ext_line(10, 2, 1'b1, 1'b0, "R7 field restart");
        for (int l = 0; l < 5; l++) ext_line(10, 2, 1'b0, 1'b0, "R6 line follow");
        ext_line(25, 4, 1'b0, 1'b0, "R6 wide pulse");

        // locked, composite input, vertical input toggling (R8)
        do_reset(1'b1, 1'b1, 1'b0);
        for (int f = 0; f < 3; f++) begin
            ext_line(LD, 2, 1'b0, 1'b1, "R8 composite lines");
            ext_line(LD, LD/2 - 1, 1'b0, 1'b1, "R8 short low no field");
            ext_line(LD, LD/2 + 2, 1'b0, 1'b1, "R8 long low field start");
            for (int l = 0; l < 5; l++) ext_line(LD, 2, 1'b0, 1'b1, "R8 lines after field");
        end

        // locked, composite in and out together (R4 R5 R8)
        do_reset(1'b1, 1'b1, 1'b1);
        ext_line(LD, LD/2 + 3, 1'b0, 1'b1, "R8 R4 field start composite out");
        for (int l = 0; l < 6; l++) ext_line(LD, 2, 1'b0, 1'b1, "R4 R5 composite both");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule